// File: doc/BRIEF.md
# Flash Command Sequencer

This block models the command layer of a small flash array that is programmed over a parallel bus. The host issues single-cycle writes, each an address/data pair. The block matches these writes against protected multi-cycle unlock sequences. A complete sequence starts one of four operations: byte program, sector erase, block erase or whole-array erase. Any write that does not fit the expected sequence drops the matcher back to idle, and nothing is changed.

Once an operation starts, an internal engine runs it for a set number of cycles. A program waits `PROG_CYCLES` cycles and then clears bits in the target byte. An erase walks its region one byte per cycle, setting each byte to all ones. While the operation runs, the block ignores all writes. Reads return a status byte instead of array data: bit 7 is the inverted data-polling bit and bit 6 is a toggle bit. Software polls these bits to find out when the operation has finished, so the block has no ready pin.

Reads take one cycle: `rdata` is updated on the clock edge that samples `rd_en`. A reset aborts any sequence or operation in progress. The array contents are kept across reset and are undefined until the first erase.

Top module: `flash_cmd_seq`

## Requirements
- R1: The writes 5555h/AAh, 2AAAh/55h, 5555h/A0h, then any address/data pair program that byte. The byte's new value is its old value ANDed with the data. Command addresses are compared on addr[15:0]; the array index is addr[ARR_AW-1:0].
- R2: The writes 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h, then data 30h at any address set every byte of that address's 2^SEC_AW-byte sector to FFh. Bytes outside the sector are not changed.
- R3: The same five-write prefix followed by data 50h sets every byte of the addressed 2^BLK_AW-byte block to FFh, and no other byte.
- R4: The same prefix followed by data 10h at address 5555h sets every byte of the array to FFh.
- R5: A write whose address or data does not match the expected step returns the matcher to idle. It starts no operation, changes no byte, and a later correct sequence still works. This includes data 10h at any address other than 5555h.
- R6: While an operation runs, every write is ignored, including complete command sequences.
- R7: A read while busy returns, in bit 7, the complement of bit 7 of the byte being written. For an erase this bit is 0.
- R8: While busy, bit 6 of the status inverts on each successive read, and bits 5:0 read as zero.
- R9: A program stays busy for exactly PROG_CYCLES cycles. An erase stays busy for one cycle per byte in its region. Status starts with the first read after the final write of the sequence.
- R10: Asserting rst_n low clears rdata to 0 and aborts any partial sequence or running operation. Reads then return array data again, and bytes the aborted erase had not yet reached keep their values.
- R11: A read while idle returns the byte stored at addr[ARR_AW-1:0] on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, released synchronously |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| rd_en | input | 1 | Bus read strobe; rdata is updated on the next edge |
| addr | input | AW | Bus address for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Array data when idle, status byte when busy |

## Verification
The hardest case to reach from the ports is a reset that arrives partway through an erase walk. The reset must come after some bytes of the region have been erased and before the rest have. The bench first programs a recognisable value into the last byte of a sector. It then starts a sector erase and makes two status reads, which places the walk at the start of the sector. It then pulls reset. After reset it reads the untouched last byte back as data, which shows that both the engine and the status path were aborted. Writes that arrive while busy are checked in a similar way: a full program sequence aimed at a second byte is sent right after launch, and that byte is read back once polling shows the first program has completed.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int CMD_AW = 16;

  localparam logic [CMD_AW-1:0] ADR_KEY_A = 16'h5555;
  localparam logic [CMD_AW-1:0] ADR_KEY_B = 16'h2AAA;

  localparam logic [7:0] KEY_A    = 8'hAA;
  localparam logic [7:0] KEY_B    = 8'h55;
  localparam logic [7:0] CMD_PGM  = 8'hA0;
  localparam logic [7:0] CMD_ERS  = 8'h80;
  localparam logic [7:0] CMD_SECT = 8'h30;
  localparam logic [7:0] CMD_BLK  = 8'h50;
  localparam logic [7:0] CMD_CHIP = 8'h10;

  typedef enum logic [1:0] {
    OP_PGM,
    OP_SECT,
    OP_BLK,
    OP_CHIP
  } op_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_K1,
    SQ_K2,
    SQ_PGM,
    SQ_E1,
    SQ_E2,
    SQ_E3
  } seq_e;
endpackage

// File: rtl/fcs_seq.sv
module fcs_seq
  import fcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              busy,
  input  logic [CMD_AW-1:0] cmd_addr,
  input  logic [7:0]        wdata,
  output logic              launch,
  output op_e               launch_op
);
  seq_e st_q, st_d;
  logic st_en;
  logic at_a, at_b;

  assign at_a  = (cmd_addr == ADR_KEY_A);
  assign at_b  = (cmd_addr == ADR_KEY_B);
  assign st_en = busy | wr_en;

  always_comb begin
    st_d      = st_q;
    launch    = 1'b0;
    launch_op = OP_PGM;
    if (busy) begin
      st_d = SQ_IDLE;
    end else if (wr_en) begin
      st_d = SQ_IDLE;
      unique case (st_q)
        SQ_IDLE: if (at_a && wdata == KEY_A) st_d = SQ_K1;
        SQ_K1:   if (at_b && wdata == KEY_B) st_d = SQ_K2;
        SQ_K2: begin
          if (at_a && wdata == CMD_PGM)      st_d = SQ_PGM;
          else if (at_a && wdata == CMD_ERS) st_d = SQ_E1;
        end
        SQ_PGM: begin
          launch    = 1'b1;
          launch_op = OP_PGM;
        end
        SQ_E1:   if (at_a && wdata == KEY_A) st_d = SQ_E2;
        SQ_E2:   if (at_b && wdata == KEY_B) st_d = SQ_E3;
        SQ_E3: begin
          if (wdata == CMD_SECT) begin
            launch    = 1'b1;
            launch_op = OP_SECT;
          end else if (wdata == CMD_BLK) begin
            launch    = 1'b1;
            launch_op = OP_BLK;
          end else if (wdata == CMD_CHIP && at_a) begin
            launch    = 1'b1;
            launch_op = OP_CHIP;
          end
        end
        default: st_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SQ_IDLE;
    end else if (st_en) begin
      st_q <= st_d;
    end
  end
endmodule

// File: rtl/fcs_engine.sv
module fcs_engine
  import fcs_pkg::*;
#(
  parameter int ARR_AW      = 11,
  parameter int SEC_AW      = 8,
  parameter int BLK_AW      = 10,
  parameter int PROG_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  op_e               launch_op,
  input  logic [ARR_AW-1:0] tgt_addr,
  input  logic [7:0]        tgt_data,
  output logic              busy,
  output logic              op_prog,
  output logic [7:0]        op_data,
  output logic              mem_we,
  output logic              mem_ones,
  output logic [ARR_AW-1:0] mem_addr
);
  localparam int CW = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1;
  localparam logic [CW-1:0]     CNT_LOAD = CW'(PROG_CYCLES - 1);
  localparam logic [ARR_AW-1:0] SEC_LOW  = ARR_AW'((1 << SEC_AW) - 1);
  localparam logic [ARR_AW-1:0] BLK_LOW  = ARR_AW'((1 << BLK_AW) - 1);
  localparam logic [ARR_AW-1:0] CHIP_LOW = '1;

  logic              busy_q, busy_d;
  op_e               op_q, op_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [ARR_AW-1:0] ptr_q, ptr_d;
  logic [ARR_AW-1:0] last_q, last_d;
  logic [7:0]        data_q, data_d;
  logic [ARR_AW-1:0] region_low;
  logic              is_pgm;
  logic              done;
  logic              eng_en;

  assign is_pgm = (op_q == OP_PGM);
  assign done   = busy_q && (is_pgm ? (cnt_q == '0) : (ptr_q == last_q));
  assign eng_en = launch | busy_q;

  always_comb begin
    unique case (launch_op)
      OP_SECT: region_low = SEC_LOW;
      OP_BLK:  region_low = BLK_LOW;
      OP_CHIP: region_low = CHIP_LOW;
      default: region_low = '0;
    endcase
  end

  always_comb begin
    busy_d = busy_q;
    op_d   = op_q;
    cnt_d  = cnt_q;
    ptr_d  = ptr_q;
    last_d = last_q;
    data_d = data_q;
    if (launch) begin
      busy_d = 1'b1;
      op_d   = launch_op;
      cnt_d  = CNT_LOAD;
      ptr_d  = tgt_addr & ~region_low;
      last_d = tgt_addr | region_low;
      data_d = (launch_op == OP_PGM) ? tgt_data : 8'hFF;
    end else if (busy_q) begin
      if (done) begin
        busy_d = 1'b0;
      end else if (is_pgm) begin
        cnt_d = cnt_q - 1'b1;
      end else begin
        ptr_d = ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      op_q   <= OP_PGM;
      cnt_q  <= '0;
      ptr_q  <= '0;
      last_q <= '0;
      data_q <= '0;
    end else if (eng_en) begin
      busy_q <= busy_d;
      op_q   <= op_d;
      cnt_q  <= cnt_d;
      ptr_q  <= ptr_d;
      last_q <= last_d;
      data_q <= data_d;
    end
  end

  assign busy     = busy_q;
  assign op_prog  = busy_q && is_pgm;
  assign op_data  = data_q;
  assign mem_we   = busy_q && (!is_pgm || cnt_q == '0);
  assign mem_ones = !is_pgm;
  assign mem_addr = ptr_q;
endmodule

// File: rtl/fcs_array.sv
module fcs_array #(
  parameter int ARR_AW = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_we,
  input  logic              mem_ones,
  input  logic [ARR_AW-1:0] mem_addr,
  input  logic [7:0]        mem_wdata,
  input  logic              rd_en,
  input  logic [ARR_AW-1:0] rd_addr,
  input  logic              busy,
  input  logic              poll_bit,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ARR_AW;

  logic [7:0] cells [DEPTH];
  logic [7:0] rdata_q, rdata_d;
  logic       tog_q, tog_d;
  logic       tog_en;

  always_ff @(posedge clk) begin
    if (mem_we) begin
      cells[mem_addr] <= mem_ones ? 8'hFF : (cells[mem_addr] & mem_wdata);
    end
  end

  assign tog_en  = rd_en && busy;
  assign tog_d   = ~tog_q;
  assign rdata_d = busy ? {poll_bit, tog_q, 6'd0} : cells[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q <= 1'b0;
    end else if (tog_en) begin
      tog_q <= tog_d;
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter int AW          = 19,
  parameter int ARR_AW      = 11,
  parameter int SEC_AW      = 8,
  parameter int BLK_AW      = 10,
  parameter int PROG_CYCLES = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic              busy;
  logic              launch;
  op_e               launch_op;
  logic              op_prog;
  logic [7:0]        op_data;
  logic              mem_we;
  logic              mem_ones;
  logic [ARR_AW-1:0] mem_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  fcs_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en),
    .busy      (busy),
    .cmd_addr  (addr[CMD_AW-1:0]),
    .wdata     (wdata),
    .launch    (launch),
    .launch_op (launch_op)
  );

  fcs_engine #(
    .ARR_AW      (ARR_AW),
    .SEC_AW      (SEC_AW),
    .BLK_AW      (BLK_AW),
    .PROG_CYCLES (PROG_CYCLES)
  ) u_engine (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .launch    (launch),
    .launch_op (launch_op),
    .tgt_addr  (addr[ARR_AW-1:0]),
    .tgt_data  (wdata),
    .busy      (busy),
    .op_prog   (op_prog),
    .op_data   (op_data),
    .mem_we    (mem_we),
    .mem_ones  (mem_ones),
    .mem_addr  (mem_addr)
  );

  fcs_array #(
    .ARR_AW (ARR_AW)
  ) u_array (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .mem_we    (mem_we),
    .mem_ones  (mem_ones),
    .mem_addr  (mem_addr),
    .mem_wdata (op_data),
    .rd_en     (rd_en),
    .rd_addr   (addr[ARR_AW-1:0]),
    .busy      (busy),
    .poll_bit  (~op_data[7]),
    .rdata     (rdata)
  );
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int PROG_CYCLES = 20
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_en,
  input logic [7:0] rdata,
  input logic       busy,
  input logic       launch,
  input logic       op_prog,
  input logic [7:0] op_data
);
  int unsigned busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_run <= 0;
    end else begin
      busy_run <= busy ? busy_run + 1 : 0;
    end
  end

  AST_STATUS_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy) |=> (rdata[5:0] == 6'd0)); // R8

  AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy && $past(rd_en && busy)) |=> (rdata[6] != $past(rdata[6]))); // R8

  AST_POLL_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy) |=> (rdata[7] == ~$past(op_data[7]))); // R7

  AST_NO_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !launch); // R6

  AST_PROG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    op_prog |-> (busy_run < PROG_CYCLES)); // R9
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(
  .PROG_CYCLES (PROG_CYCLES)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .rd_en   (rd_en),
  .rdata   (rdata),
  .busy    (busy),
  .launch  (launch),
  .op_prog (op_prog),
  .op_data (op_data)
);

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;
  localparam int AW          = 19;
  localparam int ARR_AW      = 11;
  localparam int SEC_AW      = 8;
  localparam int BLK_AW      = 10;
  localparam int PROG_CYCLES = 20;

  logic          clk;
  logic          rst_n;
  logic          wr_en;
  logic          rd_en;
  logic [AW-1:0] addr;
  logic [7:0]    wdata;
  logic [7:0]    rdata;

  int checks;
  int fails;

  flash_cmd_seq #(
    .AW (AW), .ARR_AW (ARR_AW), .SEC_AW (SEC_AW),
    .BLK_AW (BLK_AW), .PROG_CYCLES (PROG_CYCLES)
  ) u_flash_cmd_seq (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .rd_en (rd_en),
    .addr (addr), .wdata (wdata), .rdata (rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic unlock();
    wr(19'h05555, 8'hAA);
    wr(19'h02AAA, 8'h55);
  endtask

  task automatic do_prog(input logic [AW-1:0] a, input logic [7:0] d);
    unlock();
    wr(19'h05555, 8'hA0);
    wr(a, d);
  endtask

  task automatic do_erase(input logic [AW-1:0] a, input logic [7:0] cmd);
    unlock();
    wr(19'h05555, 8'h80);
    unlock();
    wr(a, cmd);
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    #1;
    chk(rdata == 8'h00, "R10 rdata cleared in reset", rdata, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // Poll from the cycle after launch; n counts status reads seen.
  task automatic poll(input logic [AW-1:0] a, input logic [7:0] exp,
                      input logic stat7, output int n);
    logic [7:0] v;
    logic       prev6;
    bit pad_ok, d7_ok, tog_ok;
    pad_ok = 1; d7_ok = 1; tog_ok = 1; prev6 = 1'b0; n = 0;
    for (int i = 0; i < 5000; i++) begin
      rd(a, v);
      if (v == exp) break;
      if (v[5:0] != 6'd0) pad_ok = 0;
      if (v[7] !== stat7) d7_ok = 0;
      if (n > 0 && v[6] == prev6) tog_ok = 0;
      prev6 = v[6];
      n++;
    end
    chk(pad_ok, "R8 status low bits zero", pad_ok, 1);
    chk(tog_ok, "R8 toggle bit alternates", tog_ok, 1);
    chk(d7_ok, "R7 polling bit", d7_ok, 1);
  endtask

  task automatic t_chip();
    int n;
    logic [7:0] v;
    do_erase(19'h05555, 8'h10);
    poll(19'h00000, 8'hFF, 1'b0, n);
    chk(n == (1 << ARR_AW), "R9 whole-array erase duration", n, 1 << ARR_AW);
    rd(19'h007FF, v);
    chk(v == 8'hFF, "R4 whole-array erase top byte", v, 8'hFF);
    rd(19'h00123, v);
    chk(v == 8'hFF, "R4 whole-array erase mid byte", v, 8'hFF);
  endtask

  task automatic t_prog();
    int n;
    logic [7:0] v;
    do_prog(19'h00010, 8'hA5);
    poll(19'h00010, 8'hA5, 1'b0, n);
    chk(n == PROG_CYCLES, "R9 program duration", n, PROG_CYCLES);
    rd(19'h00010, v);
    chk(v == 8'hA5, "R1 programmed byte", v, 8'hA5);
    do_prog(19'h00010, 8'h5E);
    poll(19'h00010, 8'h04, 1'b1, n);
    chk(n == PROG_CYCLES, "R9 second program duration", n, PROG_CYCLES);
    rd(19'h00010, v);
    chk(v == 8'h04, "R1 program ANDs with old value", v, 8'h04);
  endtask

  task automatic t_idle_read();
    logic [7:0] v;
    rd(19'h00011, v);
    chk(v == 8'hFF, "R11 idle read erased byte", v, 8'hFF);
    rd(19'h40010, v);
    chk(v == 8'h04, "R11 idle read uses low address bits", v, 8'h04);
  endtask

  task automatic t_sector();
    int n;
    logic [7:0] v;
    do_prog(19'h00100, 8'h11); poll(19'h00100, 8'h11, 1'b1, n);
    do_prog(19'h001FF, 8'h22); poll(19'h001FF, 8'h22, 1'b1, n);
    do_prog(19'h00200, 8'h33); poll(19'h00200, 8'h33, 1'b1, n);
    do_prog(19'h000FF, 8'h44); poll(19'h000FF, 8'h44, 1'b1, n);
    do_erase(19'h00180, 8'h30);
    poll(19'h00180, 8'hFF, 1'b0, n);
    chk(n == (1 << SEC_AW), "R9 sector erase duration", n, 1 << SEC_AW);
    rd(19'h00100, v); chk(v == 8'hFF, "R2 sector first byte", v, 8'hFF);
    rd(19'h001FF, v); chk(v == 8'hFF, "R2 sector last byte", v, 8'hFF);
    rd(19'h00200, v); chk(v == 8'h33, "R2 next sector kept", v, 8'h33);
    rd(19'h000FF, v); chk(v == 8'h44, "R2 previous sector kept", v, 8'h44);
  endtask

  task automatic t_block();
    int n;
    logic [7:0] v;
    do_prog(19'h00400, 8'h12); poll(19'h00400, 8'h12, 1'b1, n);
    do_prog(19'h007FF, 8'h34); poll(19'h007FF, 8'h34, 1'b1, n);
    do_prog(19'h003FF, 8'h56); poll(19'h003FF, 8'h56, 1'b1, n);
    do_erase(19'h00555, 8'h50);
    poll(19'h00555, 8'hFF, 1'b0, n);
    chk(n == (1 << BLK_AW), "R9 block erase duration", n, 1 << BLK_AW);
    rd(19'h00400, v); chk(v == 8'hFF, "R3 block first byte", v, 8'hFF);
    rd(19'h007FF, v); chk(v == 8'hFF, "R3 block last byte", v, 8'hFF);
    rd(19'h003FF, v); chk(v == 8'h56, "R3 other block kept", v, 8'h56);
    rd(19'h000FF, v); chk(v == 8'h44, "R3 other block kept low", v, 8'h44);
  endtask

  task automatic t_abort();
    int n;
    logic [7:0] v;
    unlock();
    wr(19'h05555, 8'hA1);
    wr(19'h00020, 8'h00);
    rd(19'h00020, v);
    chk(v == 8'hFF, "R5 bad command byte starts nothing", v, 8'hFF);
    wr(19'h02AAA, 8'h55);
    wr(19'h05555, 8'hA0);
    wr(19'h00021, 8'h00);
    rd(19'h00021, v);
    chk(v == 8'hFF, "R5 sequence without first key ignored", v, 8'hFF);
    do_erase(19'h01234, 8'h10);
    rd(19'h003FF, v);
    chk(v == 8'h56, "R5 whole-array erase at wrong address ignored", v, 8'h56);
    do_prog(19'h00020, 8'h77);
    poll(19'h00020, 8'h77, 1'b1, n);
    chk(n == PROG_CYCLES, "R5 correct sequence works after abort", n, PROG_CYCLES);
  endtask

  task automatic t_busy_ignore();
    int n;
    logic [7:0] v;
    do_prog(19'h00030, 8'h0F);
    unlock();
    wr(19'h05555, 8'hA0);
    wr(19'h00031, 8'h00);
    poll(19'h00030, 8'h0F, 1'b1, n);
    chk(n == PROG_CYCLES - 4, "R6 program ran through ignored writes", n, PROG_CYCLES - 4);
    rd(19'h00031, v);
    chk(v == 8'hFF, "R6 writes during busy ignored", v, 8'hFF);
  endtask

  task automatic t_reset_abort();
    int n;
    logic [7:0] v;
    do_prog(19'h005FF, 8'h3C); poll(19'h005FF, 8'h3C, 1'b1, n);
    do_erase(19'h00500, 8'h30);
    rd(19'h00500, v);
    chk(v[5:0] == 6'd0 && v[7] == 1'b0, "R7 status after erase launch", v, 8'h00);
    rd(19'h00500, v);
    apply_reset();
    rd(19'h005FF, v);
    chk(v == 8'h3C, "R10 erase aborted, data read resumes", v, 8'h3C);
    unlock();
    apply_reset();
    wr(19'h05555, 8'hA0);
    wr(19'h00600, 8'h00);
    rd(19'h00600, v);
    chk(v == 8'hFF, "R10 partial sequence aborted by reset", v, 8'hFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    checks = 0; fails = 0;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    chk(rdata == 8'h00, "R10 reset state of rdata", rdata, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_chip();
    t_prog();
    t_idle_read();
    t_sector();
    t_block();
    t_abort();
    t_busy_ignore();
    t_reset_abort();
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule